// File: doc/BRIEF.md
# Extended-range interrupt set-pending register bank

This block keeps the pending state of a bank of shared peripheral interrupts in the extended range, whose numbers start at 4096. Software marks interrupts pending through thirty-two word-wide registers on a simple register bus. Each write is write-one-to-set, and a read returns the pending bits that the requester may see. Beside the pending bit, every interrupt has an active flag. Hardware acknowledge and deactivate inputs move interrupts between the inactive, pending, active and active-and-pending states.

Each bit's visibility depends on several gates. A bank-wide enable for the extended range must be on. A per-interrupt implemented mask must be set. The affinity-routing enable that belongs to the interrupt's security group must be on. When the security-disable control is low, a non-secure access cannot see or touch secure-group interrupts. A fully masked pending vector leaves the block on every cycle for the downstream arbiter.

Top module: `spi_setpend_bank`

## Requirements
- R1: While reset is high and in the first cycle after it, every pending bit, every active flag and the read data are zero.
- R2: Register n sits at byte offset 0x1600 + 4*n, for n from 0 to 31. Bit b of register n stands for interrupt 4096 + 32*n + b. A read strobe returns that register's visible pending bits on bus_rdata one cycle later.
- R3: Writing 1 to a visible bit sets its pending bit, whether the interrupt is inactive or active. Writing 0 changes nothing, and a write never changes an active flag.
- R4: A strobe to an offset outside 0x1600..0x167C, or to an offset that is not a multiple of 4, has no effect on any state. A read there returns zero. On any cycle that does not follow a read strobe, bus_rdata is zero.
- R5: irq_group_ns[i]=1 places interrupt i in the non-secure group, and 0 places it in the secure group. With cfg_sec_disable=0, a non-secure access (bus_secure=0) reads secure-group bits as 0 and its writes to them are dropped. Secure accesses, and all accesses when cfg_sec_disable=1, are not gated by group.
- R6: An interrupt with irq_impl[i]=0 reads as 0, ignores writes and shows 0 on pend_out.
- R7: With cfg_ext_present=0, the whole bank reads as 0 and ignores writes, and pend_out is all zero.
- R8: cfg_route_s gates the secure-group interrupts and cfg_route_ns gates the non-secure ones. When the gating enable is 0, the interrupt reads as 0, ignores writes and is 0 on pend_out.
- R9: hw_ack[i] on a pending interrupt clears its pending bit and sets its active flag, so that pending becomes active and active-and-pending becomes active. An acknowledge on an interrupt that is not pending changes nothing.
- R10: When a set-pending write and hw_ack reach the same interrupt in the same cycle, the interrupt ends up active and pending.
- R11: hw_deact[i] clears the active flag. If an acknowledge that takes effect arrives in the same cycle, the interrupt stays active.
- R12: On every cycle, pend_out[i] is the pending bit ANDed with the R6, R7 and R8 gates. active_out shows the unmasked active flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (16) | Byte offset of the access |
| bus_wdata | input | 32 | Write data, one bit per interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | 1 for a secure access |
| bus_rdata | output | 32 | Read data, registered |
| cfg_sec_disable | input | 1 | 1 lifts the security-group gate |
| cfg_ext_present | input | 1 | Extended range present |
| cfg_route_s | input | 1 | Affinity routing on for the secure group |
| cfg_route_ns | input | 1 | Affinity routing on for the non-secure group |
| irq_group_ns | input | 32*NREG | Group per interrupt, 1 = non-secure |
| irq_impl | input | 32*NREG | Implemented mask |
| hw_ack | input | 32*NREG | Acknowledge per interrupt |
| hw_deact | input | 32*NREG | Deactivate per interrupt |
| pend_out | output | 32*NREG | Masked pending vector |
| active_out | output | 32*NREG | Active flags |

## Verification
The bench aims at the edges of the address window: offsets 0x15FC and 0x1680 and a misaligned 0x1602. A decoder with a loose limit or no alignment check would set bits there or return stale data. It tests the security gate in both directions and with the disable override. A wrong sense of the group bit would let a non-secure write set secure interrupts, or would hide non-secure ones. It also checks that a write dropped while the range or a routing enable was off does not show up later, when the gate reopens. Finally it drives an acknowledge in the same cycle as a write, and a deactivate in the same cycle as an acknowledge. A wrong priority there loses the new pending bit or drops the active flag.

// File: rtl/spi_pend_pkg.sv
package spi_pend_pkg;
  localparam int WORD_W = 32;
  localparam int EXT_INTID_BASE = 4096;

  typedef struct packed {
    logic sec_disable;
    logic ext_present;
    logic route_s;
    logic route_ns;
  } spi_cfg_t;
endpackage

// File: rtl/spi_pend_decode.sv
module spi_pend_decode #(
  parameter int AW = 16,
  parameter int NREG = 32,
  parameter logic [AW-1:0] BASE = 16'h1600,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  localparam logic [AW-1:0] SPAN = AW'(NREG * 4);

  logic [AW-1:0] rel;

  always_comb begin
    rel = addr - BASE;
    hit = (addr[1:0] == 2'b00) && (addr >= BASE) && (rel < SPAN);
    idx = rel[IW+1:2];
  end
endmodule

// File: rtl/spi_pend_access.sv
module spi_pend_access
  import spi_pend_pkg::*;
#(
  parameter int N = 1024
) (
  input  spi_cfg_t     cfg,
  input  logic         req_secure,
  input  logic [N-1:0] grp_ns,
  input  logic [N-1:0] impl,
  output logic [N-1:0] avail,
  output logic [N-1:0] vis
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // routing enable chosen by the interrupt's own group
    assign avail[i] = cfg.ext_present & impl[i] &
                      (grp_ns[i] ? cfg.route_ns : cfg.route_s);
    assign vis[i]   = avail[i] & (req_secure | cfg.sec_disable | grp_ns[i]);
  end
endmodule

// File: rtl/spi_pend_state.sv
module spi_pend_state #(
  parameter int N = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] deact,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] act_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
      end else begin
        // a same-cycle set survives the acknowledge
        pend_q[i] <= set_req[i] | (pend_q[i] & ~ack[i]);
        act_q[i]  <= (act_q[i] & ~deact[i]) | (ack[i] & (pend_q[i] | set_req[i]));
      end
    end
  end
endmodule

// File: rtl/spi_setpend_bank.sv
module spi_setpend_bank
  import spi_pend_pkg::*;
#(
  parameter int AW = 16,
  parameter int NREG = 32,
  parameter logic [AW-1:0] BASE = 16'h1600,
  localparam int N = NREG * WORD_W,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_secure,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                cfg_sec_disable,
  input  logic                cfg_ext_present,
  input  logic                cfg_route_s,
  input  logic                cfg_route_ns,
  input  logic [N-1:0]        irq_group_ns,
  input  logic [N-1:0]        irq_impl,
  input  logic [N-1:0]        hw_ack,
  input  logic [N-1:0]        hw_deact,
  output logic [N-1:0]        pend_out,
  output logic [N-1:0]        active_out
);
  spi_cfg_t      cfg;
  logic          hit;
  logic [IW-1:0] idx;
  logic [N-1:0]  avail, vis, set_vec, pend_q, act_q, pend_vis;

  assign cfg = '{sec_disable: cfg_sec_disable, ext_present: cfg_ext_present,
                 route_s: cfg_route_s, route_ns: cfg_route_ns};

  spi_pend_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  spi_pend_access #(.N(N)) u_acc (
    .cfg(cfg), .req_secure(bus_secure), .grp_ns(irq_group_ns),
    .impl(irq_impl), .avail(avail), .vis(vis)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_wr
    assign set_vec[r*WORD_W +: WORD_W] =
      (bus_wr && hit && (idx == IW'(r))) ? (bus_wdata & vis[r*WORD_W +: WORD_W])
                                         : '0;
  end

  spi_pend_state #(.N(N)) u_st (
    .clk(clk), .rst(rst), .set_req(set_vec), .ack(hw_ack),
    .deact(hw_deact), .pend_q(pend_q), .act_q(act_q)
  );

  assign pend_vis = pend_q & vis;

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd && hit)
      bus_rdata <= pend_vis[idx*WORD_W +: WORD_W];
    else
      bus_rdata <= '0;
  end

  assign pend_out   = pend_q & avail;
  assign active_out = act_q;
endmodule

// File: rtl/spi_setpend_chk.sv
module spi_setpend_chk #(
  parameter int AW = 16,
  parameter int NREG = 32,
  parameter logic [AW-1:0] BASE = 16'h1600,
  localparam int N = NREG * 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic          cfg_ext_present,
  input logic [N-1:0]  irq_impl,
  input logic [N-1:0]  hw_ack,
  input logic [N-1:0]  hw_deact,
  input logic [N-1:0]  pend_out,
  input logic [N-1:0]  active_out
);
  localparam logic [AW-1:0] LAST = BASE + AW'(4 * (NREG - 1));

  logic bad_addr;
  assign bad_addr = (bus_addr[1:0] != 2'b00) || (bus_addr < BASE) || (bus_addr > LAST);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pend_out == '0 && active_out == '0 && bus_rdata == '0));

  assert_bad_addr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bad_addr) |=> (bus_rdata == '0));

  assert_idle_rdata_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_impl_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_out & ~irq_impl) == '0);

  assert_ext_off_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_ext_present |-> (pend_out == '0));

  assert_active_source_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((active_out & ~$past(active_out) & ~$past(hw_ack)) == '0));

  assert_deact_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (|(hw_deact & ~hw_ack)) |=> ((active_out & $past(hw_deact & ~hw_ack)) == '0));
endmodule

bind spi_setpend_bank spi_setpend_chk #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .cfg_ext_present(cfg_ext_present),
  .irq_impl(irq_impl), .hw_ack(hw_ack), .hw_deact(hw_deact),
  .pend_out(pend_out), .active_out(active_out)
);

// File: tb/sim_spi_setpend_bank.sv
`timescale 1ns/1ps
module sim_spi_setpend_bank;
  localparam int N = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
  logic [31:0] bus_rdata;
  logic sd = 1'b0, ext = 1'b1, rt_s = 1'b1, rt_ns = 1'b1;
  logic [N-1:0] grp = '1, impl = '1, ack = '0, deact = '0;
  logic [N-1:0] pend_out, active_out;

  logic [N-1:0] m_pend = '0, m_act = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_setpend_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .cfg_sec_disable(sd), .cfg_ext_present(ext),
    .cfg_route_s(rt_s), .cfg_route_ns(rt_ns), .irq_group_ns(grp),
    .irq_impl(impl), .hw_ack(ack), .hw_deact(deact),
    .pend_out(pend_out), .active_out(active_out)
  );

  function automatic bit bhit(input logic [15:0] a);
    return (a[1:0] == 2'b00) && (a >= 16'h1600) && (a <= 16'h167C);
  endfunction

  function automatic int bidx(input logic [15:0] a);
    return int'((a - 16'h1600) >> 2);
  endfunction

  function automatic logic [N-1:0] avail_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = ext & impl[i] & (grp[i] ? rt_ns : rt_s);
    return v;
  endfunction

  function automatic logic [N-1:0] vis_vec(input logic sec);
    logic [N-1:0] v;
    logic [N-1:0] av;
    av = avail_vec();
    for (int i = 0; i < N; i++)
      v[i] = av[i] & (sec | sd | grp[i]);
    return v;
  endfunction

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input string what, input logic [N-1:0] act,
                      input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [15:0] a, input logic [31:0] wd, input logic sec,
                      input logic [N-1:0] ak, input logic [N-1:0] dk);
    logic [31:0] exp_rd;
    logic [N-1:0] vv, tmp, setv, np, na;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; bus_secure = sec;
    ack = ak; deact = dk;
    vv = vis_vec(sec);
    tmp = m_pend & vv;
    exp_rd = '0;
    if (rd && bhit(a)) exp_rd = tmp[bidx(a)*32 +: 32];
    setv = '0;
    if (wr && bhit(a))
      for (int b = 0; b < 32; b++) setv[bidx(a)*32 + b] = wd[b] & vv[bidx(a)*32 + b];
    np = setv | (m_pend & ~ak);
    na = (m_act & ~dk) | (ak & (m_pend | setv));
    @(posedge clk);
    #1;
    m_pend = np;
    m_act = na;
    chk32(tag, bus_rdata, exp_rd);
    chkv(tag, "pend_out", pend_out, m_pend & avail_vec());
    chkv(tag, "active_out", active_out, m_act);
  endtask

  task automatic wr_reg(input string tag, input int r, input logic [31:0] d, input logic sec);
    step(tag, 1'b1, 1'b0, 16'h1600 + 16'(4*r), d, sec, '0, '0);
  endtask

  task automatic rd_reg(input string tag, input int r, input logic sec);
    step(tag, 1'b0, 1'b1, 16'h1600 + 16'(4*r), '0, sec, '0, '0);
  endtask

  function automatic logic [N-1:0] one(input int i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] z;
    z = '0;
    void'($urandom(32'd91));
    repeat (3) @(posedge clk);
    #1;
    // R1: state and read data during reset
    chkv("R1", "pend_out", pend_out, '0);
    chkv("R1", "active_out", active_out, '0);
    chk32("R1", bus_rdata, '0);
    @(negedge clk);
    rst = 1'b0;

    // R2 map and read latency; top interrupt 4096+1023
    wr_reg("R2", 5, 32'hA5A5_0001, 1'b0);
    rd_reg("R2", 5, 1'b0);
    rd_reg("R2", 4, 1'b0);
    wr_reg("R2", 31, 32'h8000_0000, 1'b0);
    rd_reg("R2", 31, 1'b1);

    // R3 zeros have no effect; set on active interrupt
    wr_reg("R3", 5, 32'h0, 1'b0);
    rd_reg("R3", 5, 1'b0);

    // R4 window edges and misalignment
    step("R4", 1'b1, 1'b0, 16'h1680, 32'hFFFF_FFFF, 1'b1, z, z);
    step("R4", 1'b1, 1'b0, 16'h15FC, 32'hFFFF_FFFF, 1'b1, z, z);
    step("R4", 1'b1, 1'b0, 16'h1602, 32'hFFFF_FFFF, 1'b1, z, z);
    step("R4", 1'b0, 1'b1, 16'h1616, 32'h0, 1'b1, z, z);
    step("R4", 1'b0, 1'b1, 16'h1680, 32'h0, 1'b1, z, z);
    rd_reg("R4", 0, 1'b1);

    // R5 security gate, reg 2 secure group
    grp[64 +: 32] = '0;
    wr_reg("R5", 2, 32'hFFFF_FFFF, 1'b0);
    rd_reg("R5", 2, 1'b1);
    wr_reg("R5", 2, 32'h0F0F_0F0F, 1'b1);
    rd_reg("R5", 2, 1'b0);
    rd_reg("R5", 2, 1'b1);
    sd = 1'b1;
    rd_reg("R5", 2, 1'b0);
    wr_reg("R5", 2, 32'hF000_0000, 1'b0);
    sd = 1'b0;
    rd_reg("R5", 2, 1'b1);

    // R6 implemented mask
    impl[96 +: 16] = '0;
    wr_reg("R6", 3, 32'hFFFF_FFFF, 1'b1);
    rd_reg("R6", 3, 1'b1);
    impl[96 +: 16] = '1;
    rd_reg("R6", 3, 1'b1);

    // R7 extended range off: dropped write stays dropped
    ext = 1'b0;
    rd_reg("R7", 5, 1'b1);
    wr_reg("R7", 7, 32'h1234_5678, 1'b1);
    ext = 1'b1;
    rd_reg("R7", 7, 1'b1);

    // R8 routing enables per group
    rt_s = 1'b0;
    rd_reg("R8", 2, 1'b1);
    wr_reg("R8", 2, 32'h00F0_0000, 1'b1);
    rt_s = 1'b1;
    rd_reg("R8", 2, 1'b1);
    rt_ns = 1'b0;
    rd_reg("R8", 5, 1'b1);
    wr_reg("R8", 6, 32'h1, 1'b1);
    rt_ns = 1'b1;
    rd_reg("R8", 6, 1'b1);

    // R9 acknowledge; interrupt 160 = reg5 bit0 pending
    step("R9", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, one(160), z);
    step("R9", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, one(161), z);
    wr_reg("R3", 5, 32'h1, 1'b0);
    rd_reg("R3", 5, 1'b0);
    step("R9", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, one(160), z);

    // R10 write and acknowledge together on an inactive interrupt
    step("R10", 1'b1, 1'b0, 16'h1620, 32'h0000_0004, 1'b0, one(258), z);
    rd_reg("R10", 8, 1'b0);

    // R11 deactivate, and deactivate with effective acknowledge
    step("R11", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, z, one(160));
    wr_reg("R11", 5, 32'h1, 1'b0);
    step("R11", 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, one(160) | one(258), one(160) | one(258));

    // R12 random traffic against the model
    for (int r = 0; r < 32; r++) begin
      impl[r*32 +: 32] = $urandom | $urandom;
      grp[r*32 +: 32]  = $urandom;
    end
    for (int k = 0; k < 600; k++) begin
      logic [15:0] a;
      logic [N-1:0] ak, dk;
      int op;
      op = $urandom % 3;
      a = ($urandom % 8 == 0) ? 16'($urandom) : 16'h1600 + 16'(4 * ($urandom % 32));
      ak = '0;
      dk = '0;
      if ($urandom % 3 == 0) ak[($urandom % 32)*32 +: 32] = $urandom & $urandom;
      if ($urandom % 4 == 0) dk[($urandom % 32)*32 +: 32] = $urandom & $urandom;
      if (k % 50 == 0) sd = ~sd;
      step("R12", op == 0, op == 1, a, $urandom & $urandom, 1'($urandom), ak, dk);
    end

    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ack = '0; deact = '0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule